// File: doc/BRIEF.md
# Two-Dimensional Parity Codec

This block guards a small rectangular bit matrix with even parity in two directions. In encode mode it takes the data bits of a ROWS by COLS matrix. It appends one check bit to every row. It adds a whole check row under the data, in which every bit makes its column even, including the column of row check bits.

In decode mode it takes the full protected grid of (ROWS+1) by (COLS+1) bits and tests every row and every column for odd weight. If exactly one row and one column fail, the bit where they cross is inverted, so a single upset anywhere in the grid is repaired. Any other failing pattern leaves the grid untouched and marks it as beyond repair.

A request is taken on a valid/ready handshake. The result, its status and the per-row and per-column failure flags come out of registers one clock later, together with an output valid pulse.

Top module: `grid_parity_codec`

## Requirements
- R1: While `rst` is high, `in_ready` is low. After a synchronous reset, `out_valid` is 0, `out_block` is all zero, `out_status` is 00 and both failure flag vectors are zero.
- R2: Grid bit (r,c) sits at index r*(COLS+1)+c of `in_block`/`out_block`. Column COLS holds row check bits and row ROWS is the check row. In encode mode (`in_mode`=0), each data row r<ROWS gets at column COLS the XOR of its data bits, and each check-row bit at column c gets the XOR of rows 0..ROWS-1 of that column. The status is 00 and the flags are zero.
- R3: In encode mode the corner bit (ROWS,COLS) equals the XOR of all row check bits, so the check row and the check column are both even.
- R4: In encode mode the input bits at check positions (column COLS or row ROWS) have no effect on any output.
- R5: In decode mode (`in_mode`=1), `out_row_fail[r]` is 1 exactly when row r, counting its check bit, has odd weight, for all ROWS+1 rows. `out_col_fail[c]` is defined the same way for all COLS+1 columns.
- R6: In decode mode, if exactly one row flag and exactly one column flag are set, the bit at their crossing is inverted and `out_status` is 01 (corrected).
- R7: If that crossing lies in the check column or the check row, the data bits come out unchanged, the check bit is restored, and `out_status` is 01.
- R8: In decode mode, any failing pattern other than the one in R6 passes the grid through unchanged with `out_status` 10 (uncorrectable).
- R9: In decode mode, a grid with no failing row or column passes through unchanged with `out_status` 00 (clean).
- R10: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high for exactly the cycle after each accepted request and low otherwise, so each request yields exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_mode | input | 1 | 0 encode, 1 decode |
| in_block | input | (ROWS+1)*(COLS+1) | Grid in; data positions only in encode mode |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| out_block | output | (ROWS+1)*(COLS+1) | Encoded or repaired grid |
| out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| out_row_fail | output | ROWS+1 | Odd-weight rows of the decoded input |
| out_col_fail | output | COLS+1 | Odd-weight columns of the decoded input |

## Verification
Encoding is tried on a known matrix with a hand-computed grid, and again with garbage at the check positions to show those bits are ignored. Every single-bit flip of that grid is decoded. Flips in data cells separate correct crossing selection from off-by-one indexing, and flips in check cells separate repair of check bits from repair of data. Two-bit flips in one row, one column and on a diagonal must all be refused as uncorrectable, which tells real crossing detection apart from picking the first failing row and column. Random grids with zero to three flips compare the status and flags against an independent model.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [1:0] {
    GS_CLEAN = 2'b00,
    GS_FIXED = 2'b01,
    GS_BAD   = 2'b10
  } gstat_e;

  typedef enum logic {
    GM_ENCODE = 1'b0,
    GM_DECODE = 1'b1
  } gmode_e;

endpackage

// File: rtl/grid_encoder.sv
module grid_encoder #(
  parameter int ROWS = 4,
  parameter int COLS = 3
) (
  input  logic [ROWS*COLS-1:0]            data_bits,
  output logic [(ROWS+1)*(COLS+1)-1:0]    coded
);
  localparam int W = COLS + 1;
  localparam int N = (ROWS + 1) * W;

  logic [N-1:0] body;

  // Data cells plus row check bits; the check row is filled below.
  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      for (c = 0; c < COLS; c++) begin : g_cell
        assign body[r*W+c] = data_bits[r*COLS+c];
      end
      assign body[r*W+COLS] = ^data_bits[r*COLS +: COLS];
    end
    for (c = 0; c < W; c++) begin : g_bot
      assign body[ROWS*W+c] = 1'b0;
    end
  endgenerate

  function automatic logic col_sum(input logic [N-1:0] g, input int col);
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < ROWS; k++) acc ^= g[k*W+col];
    return acc;
  endfunction

  generate
    for (r = 0; r < ROWS; r++) begin : g_copy
      assign coded[r*W +: W] = body[r*W +: W];
    end
    for (c = 0; c < W; c++) begin : g_chk
      assign coded[ROWS*W+c] = col_sum(body, c);
    end
  endgenerate

endmodule

// File: rtl/grid_syndrome.sv
module grid_syndrome #(
  parameter int ROWS = 4,
  parameter int COLS = 3
) (
  input  logic [(ROWS+1)*(COLS+1)-1:0] grid,
  output logic [ROWS:0]                row_fail,
  output logic [COLS:0]                col_fail
);
  localparam int W = COLS + 1;
  localparam int N = (ROWS + 1) * W;

  function automatic logic col_odd(input logic [N-1:0] g, input int col);
    logic acc;
    acc = 1'b0;
    for (int k = 0; k <= ROWS; k++) acc ^= g[k*W+col];
    return acc;
  endfunction

  genvar r, c;
  generate
    for (r = 0; r <= ROWS; r++) begin : g_rf
      assign row_fail[r] = ^grid[r*W +: W];
    end
    for (c = 0; c <= COLS; c++) begin : g_cf
      assign col_fail[c] = col_odd(grid, c);
    end
  endgenerate

endmodule

// File: rtl/grid_fixer.sv
module grid_fixer
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 3
) (
  input  logic [(ROWS+1)*(COLS+1)-1:0] grid_in,
  input  logic [ROWS:0]                row_fail,
  input  logic [COLS:0]                col_fail,
  output logic [(ROWS+1)*(COLS+1)-1:0] grid_out,
  output logic [(ROWS+1)*(COLS+1)-1:0] flip_mask,
  output logic [1:0]                   status
);
  localparam int W = COLS + 1;

  logic any_fail;
  logic one_cross;

  assign any_fail  = (|row_fail) | (|col_fail);
  assign one_cross = $onehot(row_fail) && $onehot(col_fail);

  genvar r, c;
  generate
    for (r = 0; r <= ROWS; r++) begin : g_r
      for (c = 0; c <= COLS; c++) begin : g_c
        assign flip_mask[r*W+c] = one_cross & row_fail[r] & col_fail[c];
      end
    end
  endgenerate

  assign grid_out = grid_in ^ flip_mask;

  always_comb begin
    if (!any_fail)      status = GS_CLEAN;
    else if (one_cross) status = GS_FIXED;
    else                status = GS_BAD;
  end

endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_mode,
  input  logic [(ROWS+1)*(COLS+1)-1:0]  in_block,
  output logic                          out_valid,
  output logic [(ROWS+1)*(COLS+1)-1:0]  out_block,
  output logic [1:0]                    out_status,
  output logic [ROWS:0]                 out_row_fail,
  output logic [COLS:0]                 out_col_fail
);
  localparam int W = COLS + 1;
  localparam int N = (ROWS + 1) * W;

  logic            accept;
  logic [ROWS*COLS-1:0] data_bits;
  logic [N-1:0]    enc_grid;
  logic [N-1:0]    fix_grid;
  logic [N-1:0]    flip_mask;
  logic [ROWS:0]   syn_row;
  logic [COLS:0]   syn_col;
  logic [1:0]      fix_status;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;

  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_dr
      for (c = 0; c < COLS; c++) begin : g_dc
        assign data_bits[r*COLS+c] = in_block[r*W+c];
      end
    end
  endgenerate

  grid_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .data_bits (data_bits),
    .coded     (enc_grid)
  );

  grid_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .grid     (in_block),
    .row_fail (syn_row),
    .col_fail (syn_col)
  );

  grid_fixer #(.ROWS(ROWS), .COLS(COLS)) u_fix (
    .grid_in   (in_block),
    .row_fail  (syn_row),
    .col_fail  (syn_col),
    .grid_out  (fix_grid),
    .flip_mask (flip_mask),
    .status    (fix_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_block    <= '0;
      out_status   <= GS_CLEAN;
      out_row_fail <= '0;
      out_col_fail <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        if (in_mode == GM_DECODE) begin
          out_block    <= fix_grid;
          out_status   <= fix_status;
          out_row_fail <= syn_row;
          out_col_fail <= syn_col;
        end else begin
          out_block    <= enc_grid;
          out_status   <= GS_CLEAN;
          out_row_fail <= '0;
          out_col_fail <= '0;
        end
      end
    end
  end

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  function automatic logic [N-1:0] data_mask_f();
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) m[i*W+j] = 1'b1;
    return m;
  endfunction

  localparam logic [N-1:0] DMASK = data_mask_f();

  function automatic logic all_even(input logic [N-1:0] g);
    logic ok;
    logic acc;
    ok = 1'b1;
    for (int i = 0; i <= ROWS; i++) if (^g[i*W +: W]) ok = 1'b0;
    for (int j = 0; j <= COLS; j++) begin
      acc = 1'b0;
      for (int i = 0; i <= ROWS; i++) acc ^= g[i*W+j];
      if (acc) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r10_result_follows: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid);

  a_r2_encoded_even: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(in_mode)) |-> all_even(out_block));

  a_r4_data_kept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(in_mode)) |-> ((out_block & DMASK) == ($past(in_block) & DMASK)));

  a_r6_single_flip: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == GS_FIXED) |-> ($countones(out_block ^ $past(in_block)) == 1));

  a_r6_fixed_is_even: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == GS_FIXED) |-> all_even(out_block));

  a_r8_bad_untouched: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == GS_BAD) |-> (out_block == $past(in_block)));

  a_r9_clean_untouched: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == GS_CLEAN && $past(in_mode)) |-> (out_block == $past(in_block)));

  a_r5_clean_no_flags: assert property (@(posedge clk) disable iff (rst)
    (out_status == GS_CLEAN) |-> (out_row_fail == '0 && out_col_fail == '0));

  a_r8_status_legal: assert property (@(posedge clk) disable iff (rst)
    out_status != 2'b11);

  a_r6_mask_single: assert property (@(posedge clk) disable iff (rst)
    $countones(flip_mask) <= 1);

endmodule

// File: tb/grid_parity_codec_tb_top.sv
`timescale 1ns/1ps
module grid_parity_codec_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int W = COLS + 1;
  localparam int N = (ROWS + 1) * W;

  typedef struct packed {
    logic [N-1:0]  blk;
    logic [1:0]    st;
    logic [ROWS:0] rf;
    logic [COLS:0] cf;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_mode = 1'b0;
  logic [N-1:0] in_block = '0;
  logic out_valid;
  logic [N-1:0] out_block;
  logic [1:0] out_status;
  logic [ROWS:0] out_row_fail;
  logic [COLS:0] out_col_fail;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int rcvd = 0;
  exp_t exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  grid_parity_codec #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_block(in_block), .out_valid(out_valid),
    .out_block(out_block), .out_status(out_status),
    .out_row_fail(out_row_fail), .out_col_fail(out_col_fail)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Independent reference built straight from the requirement text.
  function automatic exp_t model(input logic m, input logic [N-1:0] b);
    exp_t e;
    int ones, nr, nc, fr, fc;
    e = '0; nr = 0; nc = 0; fr = 0; fc = 0;
    if (!m) begin
      for (int r = 0; r < ROWS; r++) begin
        ones = 0;
        for (int c = 0; c < COLS; c++) begin
          e.blk[r*W+c] = b[r*W+c];
          ones += int'(b[r*W+c]);
        end
        e.blk[r*W+COLS] = ones[0];
      end
      for (int c = 0; c < W; c++) begin
        ones = 0;
        for (int r = 0; r < ROWS; r++) ones += int'(e.blk[r*W+c]);
        e.blk[ROWS*W+c] = ones[0];
      end
    end else begin
      for (int r = 0; r <= ROWS; r++) begin
        ones = 0;
        for (int c = 0; c <= COLS; c++) ones += int'(b[r*W+c]);
        e.rf[r] = ones[0];
        if (ones[0]) begin nr++; fr = r; end
      end
      for (int c = 0; c <= COLS; c++) begin
        ones = 0;
        for (int r = 0; r <= ROWS; r++) ones += int'(b[r*W+c]);
        e.cf[c] = ones[0];
        if (ones[0]) begin nc++; fc = c; end
      end
      e.blk = b;
      if (nr == 0 && nc == 0) e.st = 2'b00;
      else if (nr == 1 && nc == 1) begin
        e.blk[fr*W+fc] = ~b[fr*W+fc];
        e.st = 2'b01;
      end else e.st = 2'b10;
    end
    return e;
  endfunction

  task automatic send_exp(input logic m, input logic [N-1:0] b, input exp_t e, input string tag);
    in_valid = 1'b1;
    in_mode  = m;
    in_block = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sent++;
    @(negedge clk);
  endtask

  task automatic send(input logic m, input logic [N-1:0] b, input string tag);
    send_exp(m, b, model(m, b), tag);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      rcvd++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected result", 64'(out_valid), 64'd0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_block == e.blk, {t, " block"}, 64'(out_block), 64'(e.blk));
        chk(out_status == e.st, {t, " status"}, 64'(out_status), 64'(e.st));
        chk({out_row_fail, out_col_fail} == {e.rf, e.cf}, "R5 flags",
            64'({out_row_fail, out_col_fail}), 64'({e.rf, e.cf}));
      end
    end
  end

  logic done = 1'b0;

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", sent, rcvd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Example data, bit c of each row value is column c.
  localparam logic [N-1:0] EX_DATA = {4'b0000, 4'b0100, 4'b0111, 4'b0101, 4'b0001};
  localparam logic [N-1:0] EX_CODE = 20'hFCF59;

  initial begin
    exp_t ez;
    logic [N-1:0] g;
    logic [N-1:0] d;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready low in reset", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
    chk(out_block == '0 && out_status == 2'b00, "R1 outputs", 64'({out_block, out_status}), 64'd0);
    chk(out_row_fail == '0 && out_col_fail == '0, "R1 flags", 64'({out_row_fail, out_col_fail}), 64'd0);
    chk(in_ready == 1'b1, "R10 ready", 64'(in_ready), 64'd1);

    // R2 / R3: known matrix, hand-computed grid
    ez = '0; ez.blk = EX_CODE;
    send_exp(1'b0, EX_DATA, ez, "R2 R3 encode example");
    // R4: garbage at check positions
    send_exp(1'b0, EX_DATA | ~20'h07777, ez, "R4 check inputs ignored");
    idle(1);
    chk(out_valid == 1'b0, "R10 idle", 64'(out_valid), 64'd0);
    idle(1);

    // R9 clean decode
    ez = '0; ez.blk = EX_CODE; ez.st = 2'b00;
    send_exp(1'b1, EX_CODE, ez, "R9 clean");

    // R6 / R7: every single flip returns the example grid
    for (int i = 0; i < N; i++) begin
      exp_t e1;
      e1 = '0;
      e1.blk = EX_CODE;
      e1.st  = 2'b01;
      e1.rf[i / W] = 1'b1;
      e1.cf[i % W] = 1'b1;
      send_exp(1'b1, EX_CODE ^ (N'(1) << i), e1,
               ((i % W) == COLS || (i / W) == ROWS) ? "R7 check-bit fix" : "R6 data fix");
    end

    // R8: double flips in one row, one column and on a diagonal
    send(1'b1, EX_CODE ^ 20'h00003, "R8 same row");
    send(1'b1, EX_CODE ^ 20'h00011, "R8 same column");
    send(1'b1, EX_CODE ^ 20'h00021, "R8 diagonal");
    idle(2);

    // Random encodes and decodes with 0..3 flips
    for (int k = 0; k < 60; k++) begin
      d = N'($urandom);
      send(1'b0, d, "R2 random encode");
      g = model(1'b0, d).blk;
      for (int f = 0; f < (k % 4); f++) g[$urandom_range(N-1, 0)] ^= 1'b1;
      send(1'b1, g, "R6 R8 random decode");
    end
    idle(3);
    chk(rcvd == sent, "R10 one result per request", 64'(rcvd), 64'(sent));
    chk(exp_q.size() == 0, "R10 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule